// File: doc/BRIEF.md
# Timer Repetition Counter with Clock-Domain Crossing

This block sits beside the main counter of a low-power timer and divides its period events. Every single-cycle autoreload-match pulse from the main counter, arriving in the kernel clock domain, steps a down-counter. When a match finds that counter at zero, the counter underflows. It then reloads from the repetition value, emits a one-cycle strobe that commits the timer's preloaded registers, and reports an update event. A repetition value of N therefore yields one update event for every N+1 timer periods.

Software programs the repetition value, two interrupt enables and a flag-clear register through a simple write port in the bus clock domain. A new repetition value travels to the kernel domain over a toggle request/acknowledge handshake with two-flop synchronizers. While the transfer is in flight the bus-side copy is held still. When the acknowledge returns, a ready flag is raised. The counter picks up the transferred value only at the next underflow, so the period already in progress always completes with the old count. Underflows are carried back to the bus domain as toggles and set a sticky update flag. A single interrupt output combines both flags, each gated by its own enable.

Top module: `tmr_rep_unit`

## Requirements
- R1: `upd_stb` is high for exactly one kernel cycle, in the cycle that follows a kernel edge where `arr_match` was high while the counter held zero. With a repetition value N in force, the strobe follows every (N+1)-th match.
- R2: The counter changes only on kernel edges where `arr_match` is high. Idle cycles without a match never produce a strobe and never shift the phase of the next strobe.
- R3: A repetition value that has been transferred takes effect only at the next underflow. The count in progress finishes with the previous value.
- R4: A write to address 0 stores `reg_wdata` as the repetition value, clears `repok_flag`, and starts a transfer. `repok_flag` rises once the transfer is done: 4 bus cycles plus 3 kernel cycles, plus synchronizer phase alignment. While a transfer is in flight, further writes to address 0 are dropped and the held value does not change.
- R5: Every underflow sets `ue_flag` in the bus domain within a few bus cycles. The flag stays set until it is cleared.
- R6: A write to address 2 clears `ue_flag` where data bit 0 is 1 and clears `repok_flag` where data bit 1 is 1. A 0 in either bit leaves that flag alone.
- R7: A write to address 1 loads the enables: data bit 0 enables the update flag and data bit 1 enables the ready flag. `irq` is high exactly when an enabled flag is set.
- R8: After reset, `ue_flag`, `repok_flag`, `irq` and `upd_stb` are low, all enables are off, and the repetition value is 0, so every match underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| ker_clk | input | 1 | Kernel-domain clock |
| ker_rst_n | input | 1 | Kernel-domain asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe (bus domain) |
| reg_addr | input | 2 | Register address: 0 repetition, 1 enables, 2 flag clear |
| reg_wdata | input | REP_W | Write data |
| arr_match | input | 1 | Single-cycle autoreload match from the main counter (kernel domain) |
| upd_stb | output | 1 | Preload-update strobe on underflow (kernel domain) |
| ue_flag | output | 1 | Sticky update-event flag (bus domain) |
| repok_flag | output | 1 | Sticky repetition-transfer-done flag (bus domain) |
| irq | output | 1 | Combined interrupt request (bus domain) |

## Verification
The bench builds the block with REP_W = 8 and two-stage synchronizers. It runs a 50 MHz bus clock against a slower kernel clock with an unrelated period, so the handshake crosses in both directions with real phase drift. An 8-bit value lets the vector table cover periods from every match up to one in eight. A dedicated test reprograms the value in the middle of a count to show that the count in progress finishes with the old value. The slow kernel clock keeps each underflow toggle wide enough for the bus side to see it, even when every match underflows.

// File: rtl/tmr_rep_pkg.sv
package tmr_rep_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_REP = 2'd0;
    localparam logic [ADDR_W-1:0] A_IEN = 2'd1;
    localparam logic [ADDR_W-1:0] A_CLR = 2'd2;

    localparam int B_UE = 0;
    localparam int B_OK = 1;
    localparam int N_SRC = 2;
endpackage

// File: rtl/tmr_rep_sync.sv
module tmr_rep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_rep_bus.sv
module tmr_rep_bus
    import tmr_rep_pkg::*;
#(
    parameter int REP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REP_W-1:0]  wdata,
    input  logic              ack_sync,
    input  logic              ue_sync,
    output logic [REP_W-1:0]  rep_val,
    output logic              req_tgl,
    output logic              ue_flag,
    output logic              ok_flag,
    output logic              irq
);
    typedef struct packed {
        logic [REP_W-1:0] rep;
        logic [N_SRC-1:0] ien;
        logic             ue;
        logic             ok;
        logic             busy;
        logic             req;
        logic             ack_seen;
        logic             ue_seen;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    ack_ev, ue_ev;

    always_comb begin
        st_d   = st_q;
        ack_ev = ack_sync != st_q.ack_seen;
        ue_ev  = ue_sync  != st_q.ue_seen;
        st_d.ack_seen = ack_sync;
        st_d.ue_seen  = ue_sync;

        if (wr) begin
            unique case (addr)
                A_REP: begin
                    if (!st_q.busy) begin
                        st_d.rep  = wdata;
                        st_d.req  = ~st_q.req;
                        st_d.busy = 1'b1;
                        st_d.ok   = 1'b0;
                    end
                end
                A_IEN: st_d.ien = wdata[N_SRC-1:0];
                A_CLR: begin
                    if (wdata[B_UE]) st_d.ue = 1'b0;
                    if (wdata[B_OK]) st_d.ok = 1'b0;
                end
                default: ;
            endcase
        end

        // event sets take priority over a clear in the same cycle
        if (ack_ev) begin
            st_d.ok   = 1'b1;
            st_d.busy = 1'b0;
        end
        if (ue_ev) st_d.ue = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rep_val = st_q.rep;
    assign req_tgl = st_q.req;
    assign ue_flag = st_q.ue;
    assign ok_flag = st_q.ok;
    assign irq     = (st_q.ue & st_q.ien[B_UE]) | (st_q.ok & st_q.ien[B_OK]);

    AST_REP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.rep)); // R4

    AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ue && !(wr && addr == A_CLR && wdata[B_UE])) |=> st_q.ue); // R6

    AST_OK_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.ok); // R4
endmodule

// File: rtl/tmr_rep_kern.sv
module tmr_rep_kern #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic [REP_W-1:0] bus_val,
    input  logic             arr_match,
    output logic             ack_tgl,
    output logic             ue_tgl,
    output logic             upd_stb
);
    typedef struct packed {
        logic             req_seen;
        logic             ack;
        logic [REP_W-1:0] val;
        logic [REP_W-1:0] cnt;
        logic             upd;
        logic             ue;
    } ker_st_t;

    ker_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;

        if (req_sync != st_q.req_seen) begin
            st_d.req_seen = req_sync;
            st_d.val      = bus_val;
            st_d.ack      = ~st_q.ack;
        end

        if (arr_match) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.val;
                st_d.upd = 1'b1;
                st_d.ue  = ~st_q.ue;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl = st_q.ack;
    assign ue_tgl  = st_q.ue;
    assign upd_stb = st_q.upd;

    AST_STB_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> $past(arr_match)); // R1

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd && !arr_match) |=> !st_q.upd); // R1

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_match |=> $stable(st_q.cnt)); // R2

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> st_q.cnt == $past(st_q.val)); // R3
endmodule

// File: rtl/tmr_rep_unit.sv
module tmr_rep_unit
    import tmr_rep_pkg::*;
#(
    parameter int REP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              ker_clk,
    input  logic              ker_rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REP_W-1:0]  reg_wdata,
    input  logic              arr_match,
    output logic              upd_stb,
    output logic              ue_flag,
    output logic              repok_flag,
    output logic              irq
);
    logic [REP_W-1:0] rep_val;
    logic req_tgl, req_sync;
    logic ack_tgl, ack_sync;
    logic ue_tgl,  ue_sync;

    tmr_rep_bus #(.REP_W(REP_W)) u_bus (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ack_sync (ack_sync),
        .ue_sync  (ue_sync),
        .rep_val  (rep_val),
        .req_tgl  (req_tgl),
        .ue_flag  (ue_flag),
        .ok_flag  (repok_flag),
        .irq      (irq)
    );

    tmr_rep_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (ker_clk), .rst_n (ker_rst_n), .din (req_tgl), .dout (req_sync)
    );
    tmr_rep_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (bus_clk), .rst_n (bus_rst_n), .din (ack_tgl), .dout (ack_sync)
    );
    tmr_rep_sync #(.STAGES(SYNC_STAGES)) u_ue_sync (
        .clk (bus_clk), .rst_n (bus_rst_n), .din (ue_tgl), .dout (ue_sync)
    );

    tmr_rep_kern #(.REP_W(REP_W)) u_kern (
        .clk       (ker_clk),
        .rst_n     (ker_rst_n),
        .req_sync  (req_sync),
        .bus_val   (rep_val),
        .arr_match (arr_match),
        .ack_tgl   (ack_tgl),
        .ue_tgl    (ue_tgl),
        .upd_stb   (upd_stb)
    );

    AST_IRQ_SOURCE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        irq |-> (ue_flag || repok_flag)); // R7
endmodule

// File: tb/tmr_rep_unit_tb.sv
module tmr_rep_unit_tb;
    localparam int REP_W = 8;
    localparam int NVEC  = 6;
    // {value N, matches M, expected strobes M/(N+1)}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd0, 8'd5,  8'd5},
        {8'd3, 8'd8,  8'd2},
        {8'd2, 8'd7,  8'd2},
        {8'd5, 8'd12, 8'd2},
        {8'd1, 8'd9,  8'd4},
        {8'd7, 8'd16, 8'd2}
    };

    logic bus_clk = 1'b0, ker_clk = 1'b0;
    logic bus_rst_n = 1'b0, ker_rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [REP_W-1:0] reg_wdata = '0;
    logic arr_match = 1'b0;
    logic upd_stb, ue_flag, repok_flag, irq;

    int n_chk = 0, n_fail = 0;
    bit pend = 1'b0;
    bit done = 1'b0;

    always #10 bus_clk = ~bus_clk;
    always #17 ker_clk = ~ker_clk;

    tmr_rep_unit #(.REP_W(REP_W)) u_dut (
        .bus_clk (bus_clk), .bus_rst_n (bus_rst_n),
        .ker_clk (ker_clk), .ker_rst_n (ker_rst_n),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .arr_match (arr_match), .upd_stb (upd_stb),
        .ue_flag (ue_flag), .repok_flag (repok_flag), .irq (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [REP_W-1:0] d);
        @(negedge bus_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_idle(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    // one match pulse; returns the strobe seen in the following kernel cycle
    task automatic kmatch(output logic got);
        @(negedge ker_clk);
        arr_match = 1'b1;
        @(negedge ker_clk);
        got = upd_stb;
        arr_match = 1'b0;
    endtask

    // write a repetition value and wait for the ready flag (R4)
    task automatic set_rep(input logic [REP_W-1:0] v);
        int lat;
        if (pend) check("R4 write before ready", 1, 0);
        bus_write(2'd0, v);
        pend = 1'b1;
        check("R4 ready cleared by write", int'(repok_flag), 0);
        lat = 0;
        while (!repok_flag && lat < 60) begin
            @(negedge bus_clk);
            lat++;
        end
        check("R4 ready flag raised", int'(repok_flag), 1);
        check("R4 crossing latency bounded", int'(lat >= 3 && lat <= 16), 1);
        pend = 1'b0;
    endtask

    // issue matches until an underflow strobe is seen
    task automatic drain(output int used);
        logic g;
        used = 0;
        g = 1'b0;
        while (!g && used < 300) begin
            kmatch(g);
            used++;
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic g;
        int used, cnt;

        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        ker_rst_n = 1'b1;
        bus_idle(3);

        // R8 reset state
        check("R8 ue_flag after reset", int'(ue_flag), 0);
        check("R8 repok_flag after reset", int'(repok_flag), 0);
        check("R8 irq after reset", int'(irq), 0);
        check("R8 upd_stb after reset", int'(upd_stb), 0);
        for (int i = 0; i < 3; i++) begin
            kmatch(g);
            check("R8 value 0 strobes every match", int'(g), 1);
        end

        // R5 flag set by underflow, sticky
        bus_idle(10);
        check("R5 ue_flag set after underflow", int'(ue_flag), 1);
        bus_idle(20);
        check("R5 ue_flag sticky", int'(ue_flag), 1);
        // R6 zero bits leave flags alone, one bit clears
        bus_write(2'd2, 8'h00);
        check("R6 zero clear keeps ue_flag", int'(ue_flag), 1);
        bus_write(2'd2, 8'h01);
        check("R6 clear bit 0 clears ue_flag", int'(ue_flag), 0);

        // vector table walk: R1
        for (int v = 0; v < NVEC; v++) begin
            set_rep(VEC[v][23:16]);
            drain(used);
            check("R1 strobe reached in drain", int'(used < 300), 1);
            cnt = 0;
            for (int m = 0; m < int'(VEC[v][15:8]); m++) begin
                kmatch(g);
                if (g) cnt++;
            end
            check($sformatf("R1 strobes for value %0d", VEC[v][23:16]), cnt, int'(VEC[v][7:0]));
        end

        // R6 clear ready flag only
        bus_write(2'd2, 8'h02);
        check("R6 clear bit 1 clears repok_flag", int'(repok_flag), 0);

        // R3 value change mid-count: old count finishes first
        set_rep(8'd3);
        drain(used);               // counter now holds 3
        kmatch(g);                 // 3 -> 2
        kmatch(g);                 // 2 -> 1
        check("R3 no strobe mid count", int'(g), 0);
        set_rep(8'd0);
        kmatch(g);                 // 1 -> 0
        check("R3 old count continues", int'(g), 0);
        kmatch(g);                 // underflow, load 0
        check("R3 underflow ends old count", int'(g), 1);
        kmatch(g);
        check("R3 new value in force after underflow", int'(g), 1);

        // R2 idle cycles do not move the counter
        set_rep(8'd2);
        drain(used);               // counter holds 2
        kmatch(g);                 // 2 -> 1
        repeat (25) begin
            @(negedge ker_clk);
            check("R2 no strobe while idle", int'(upd_stb), 0);
        end
        kmatch(g);                 // 1 -> 0
        check("R2 phase kept after idle", int'(g), 0);
        kmatch(g);
        check("R2 strobe on third match", int'(g), 1);

        // R4 write while in flight dropped: second value never lands
        bus_write(2'd2, 8'h03);
        bus_write(2'd0, 8'd5);
        bus_write(2'd0, 8'd0);     // deliberately during transfer, must be ignored
        bus_idle(30);
        check("R4 ready after first write", int'(repok_flag), 1);
        drain(used);               // ends the count of 2
        cnt = 0;
        for (int m = 0; m < 12; m++) begin
            kmatch(g);
            if (g) cnt++;
        end
        check("R4 held value 5 in force", cnt, 2);

        // R7 interrupt combining
        bus_idle(10);
        bus_write(2'd2, 8'h02);    // ue set, ready cleared
        bus_write(2'd1, 8'h00);
        check("R7 irq low with enables off", int'(irq), 0);
        bus_write(2'd1, 8'h01);
        check("R7 irq from enabled ue_flag", int'(irq), 1);
        bus_write(2'd1, 8'h02);
        check("R7 irq low when only ready enabled and clear", int'(irq), 0);
        set_rep(8'd1);
        check("R7 irq from enabled repok_flag", int'(irq), 1);
        bus_write(2'd2, 8'h02);
        check("R7 irq drops on clear", int'(irq), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule